// File: doc/BRIEF.md
# Fractional Audio Sample-Clock Generator

This block turns a stream of single-cycle master ticks into a single-cycle sample strobe whose rate is a rational fraction of the tick rate. Two tick streams are offered to it: one from the 44.1 kHz audio master family and one from the 48 kHz family. A one-bit base select register picks which stream drives the divider. A 32-bit rate word sets the fraction through an increment and a modulus. Each accepted tick adds the increment to an accumulator. When the accumulator reaches the modulus it wraps back by the modulus and the block emits one strobe. The long-run output rate is therefore tick rate × increment / modulus.

The modulus is not stored directly. The upper half of the rate word carries the precomputed term (increment − modulus − 1) truncated to 16 bits, and the block recovers the modulus from it. Software sets the modulus to 4 × base / wanted rate and uses the base whose division leaves the smaller remainder. Sample rates from 8 kHz to 48 kHz are covered that way. A chip uses two copies of the block, one for the playback path and one for the record path. Generating the master clocks and converting samples are outside the block.

Top module: `frac_rate_gen`

## Requirements
- R1: While reset is asserted, and directly after it, `sampleStb` is low. The base select resets to 0 and the rate word resets to increment 0 with correction 0xFFFF, which is an illegal setting.
- R2: A base select value of 1 makes `tick44k` the counted stream and a value of 0 makes `tick48k` the counted stream. Ticks on the stream that is not selected have no effect on the accumulator or the output.
- R3: A write to the rate word puts the increment in bits 15:0 and the correction term in bits 31:16. The modulus in force is (increment − correction − 1) mod 2^16.
- R4: On each counted tick the accumulator adds the increment. If the sum is at least the modulus, the accumulator becomes sum − modulus and `sampleStb` goes high in the clock cycle that follows the tick.
- R5: `sampleStb` is high for exactly one cycle per wrapping tick. It is never high in a cycle that follows a cycle without a counted tick.
- R6: Starting from a cleared accumulator with a legal setting, the number of strobes after k counted ticks is floor(k × increment / modulus).
- R7: A rate word write clears the accumulator to zero. A counted tick in the same cycle as that write is dropped and produces no strobe.
- R8: A setting whose modulus is zero or smaller than the increment is illegal. While it is in force the output stays low and the accumulator stays at zero.
- R9: When the modulus equals the increment, every counted tick produces a strobe.
- R10: The full 16-bit range of increment and modulus is honoured, including sums that exceed 16 bits before the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick44k | input | 1 | Single-cycle tick from the 44.1 kHz family master |
| tick48k | input | 1 | Single-cycle tick from the 48 kHz family master |
| baseWrEn | input | 1 | Write enable of the base select register |
| baseWrData | input | 1 | Base select value: 1 picks tick44k, 0 picks tick48k |
| rateWrEn | input | 1 | Write enable of the rate word |
| rateWrData | input | 32 | Rate word: increment in 15:0, correction term in 31:16 |
| sampleStb | output | 1 | Single-cycle sample strobe |

## Verification
The checker watches several properties on every cycle. It checks that the strobe stays low during reset and that every strobe follows a tick on the stream selected at that time. It also checks that no strobe follows a rate word write, that no strobe appears while the shadowed setting is illegal, and that each counted tick under an equal increment and modulus is followed by a strobe. The exact timing of wraps, the accumulator values carried across ticks, the strobe counts over a run and the decoding of wide field values are shown only by the bench. The bench sweeps many small increment and modulus pairs on both bases and adds a few full-width settings, comparing each tick against an arithmetic model.

// File: rtl/srgen_pkg.sv
package srgen_pkg;

  // Command strobes from the control half to the accumulator datapath.
  typedef struct packed {
    logic clear;  // force accumulator to zero, no strobe
    logic step;   // add the increment this cycle
  } accCmd_t;

endpackage

// File: rtl/srgen_ctrl.sv
module srgen_ctrl
  import srgen_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick44k,
  input  logic               tick48k,
  input  logic               baseWrEn,
  input  logic               baseWrData,
  input  logic               rateWrEn,
  input  logic [2*ACC_W-1:0] rateWrData,
  output accCmd_t            cmd,
  output logic [ACC_W-1:0]   incOut,
  output logic [ACC_W-1:0]   modOut
);

  localparam int CTL_W = 2 * ACC_W;

  logic             baseSel;
  logic [ACC_W-1:0] incReg;
  logic [ACC_W-1:0] corrReg;
  logic [ACC_W-1:0] modVal;
  logic             cfgLegal;
  logic             selTick;

  // Base select register: 1 = 44.1k family, 0 = 48k family.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseSel <= 1'b0;
    end else if (baseWrEn) begin
      baseSel <= baseWrData;
    end
  end

  // Rate word: increment low half, correction term high half.
  // The reset pair decodes to modulus 0, an illegal setting.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incReg  <= '0;
      corrReg <= '1;
    end else if (rateWrEn) begin
      incReg  <= rateWrData[ACC_W-1:0];
      corrReg <= rateWrData[CTL_W-1:ACC_W];
    end
  end

  // Recover the modulus from the stored correction term.
  always_comb begin
    modVal   = incReg - corrReg - ACC_W'(1);
    cfgLegal = (modVal != '0) && (modVal >= incReg);
  end

  assign selTick = baseSel ? tick44k : tick48k;

  always_comb begin
    cmd.clear = rateWrEn || !cfgLegal;
    cmd.step  = selTick && cfgLegal && !rateWrEn;
  end

  assign incOut = incReg;
  assign modOut = modVal;

endmodule

// File: rtl/srgen_dp.sv
module srgen_dp
  import srgen_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  accCmd_t          cmd,
  input  logic [ACC_W-1:0] inc,
  input  logic [ACC_W-1:0] modulus,
  output logic             sampleStb
);

  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;
  logic             wrapHit;
  logic [ACC_W-1:0] accNext;

  always_comb begin
    sum     = {1'b0, acc} + {1'b0, inc};
    wrapHit = sum >= {1'b0, modulus};
    wrapped = sum - {1'b0, modulus};
    accNext = wrapHit ? wrapped[ACC_W-1:0] : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      sampleStb <= 1'b0;
    end else if (cmd.clear) begin
      acc       <= '0;
      sampleStb <= 1'b0;
    end else if (cmd.step) begin
      acc       <= accNext;
      sampleStb <= wrapHit;
    end else begin
      sampleStb <= 1'b0;
    end
  end

endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
  import srgen_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick44k,
  input  logic               tick48k,
  input  logic               baseWrEn,
  input  logic               baseWrData,
  input  logic               rateWrEn,
  input  logic [2*ACC_W-1:0] rateWrData,
  output logic               sampleStb
);

  accCmd_t          cmd;
  logic [ACC_W-1:0] incBus;
  logic [ACC_W-1:0] modBus;

  srgen_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick44k    (tick44k),
    .tick48k    (tick48k),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .rateWrEn   (rateWrEn),
    .rateWrData (rateWrData),
    .cmd        (cmd),
    .incOut     (incBus),
    .modOut     (modBus)
  );

  srgen_dp #(.ACC_W(ACC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .inc       (incBus),
    .modulus   (modBus),
    .sampleStb (sampleStb)
  );

endmodule

// File: rtl/frac_rate_gen_chk.sv
module frac_rate_gen_chk #(
  parameter int ACC_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick44k,
  input logic               tick48k,
  input logic               baseWrEn,
  input logic               baseWrData,
  input logic               rateWrEn,
  input logic [2*ACC_W-1:0] rateWrData,
  input logic               sampleStb
);

  // Shadow of the software-visible settings, built from port traffic only.
  logic             shSel;
  logic [ACC_W-1:0] shInc;
  logic [ACC_W-1:0] shCorr;
  logic [ACC_W-1:0] shMod;
  logic             shLegal;
  logic             shTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shSel  <= 1'b0;
      shInc  <= '0;
      shCorr <= '1;
    end else begin
      if (baseWrEn) shSel <= baseWrData;
      if (rateWrEn) begin
        shInc  <= rateWrData[ACC_W-1:0];
        shCorr <= rateWrData[2*ACC_W-1:ACC_W];
      end
    end
  end

  always_comb begin
    shMod   = shInc - shCorr - ACC_W'(1);
    shLegal = (shMod != '0) && !(shMod < shInc);
    shTick  = shSel ? tick44k : tick48k;
  end

  // R1: strobe low while reset is held
  p_reset_low_r1: assert property (@(posedge clk) !rstN |-> !sampleStb);

  // R2 / R5: every strobe follows a tick on the selected stream
  p_from_sel_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> $past(shTick));

  // R7: nothing comes out right after a rate word write
  p_quiet_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    rateWrEn |=> !sampleStb);

  // R8: no strobe under an illegal setting
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> shLegal);

  // R9: equal increment and modulus strobe on each counted tick
  p_every_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (shLegal && (shMod == shInc) && shTick && !rateWrEn) |=> sampleStb);

endmodule

bind frac_rate_gen frac_rate_gen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tick44k    (tick44k),
  .tick48k    (tick48k),
  .baseWrEn   (baseWrEn),
  .baseWrData (baseWrData),
  .rateWrEn   (rateWrEn),
  .rateWrData (rateWrData),
  .sampleStb  (sampleStb)
);

// File: tb/tb_frac_rate_gen.sv
module tb_frac_rate_gen;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick44k = 1'b0;
  logic        tick48k = 1'b0;
  logic        baseWrEn = 1'b0;
  logic        baseWrData = 1'b0;
  logic        rateWrEn = 1'b0;
  logic [31:0] rateWrData = '0;
  logic        sampleStb;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  int mInc = 0;
  int mMod = 0;
  int mAcc = 0;
  int mSel = 0;
  int mCount = 0;

  frac_rate_gen #(.ACC_W(ACC_W)) dut (
    .clk(clk), .rstN(rstN), .tick44k(tick44k), .tick48k(tick48k),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .rateWrEn(rateWrEn), .rateWrData(rateWrData), .sampleStb(sampleStb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit legal();
    return (mMod != 0) && (mMod >= mInc);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (inc=%0d mod=%0d)", req, act, exp, mInc, mMod);
    end
  endtask

  task automatic writeBase(input int v);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = v[0];
    @(negedge clk);
    baseWrEn = 1'b0;
    mSel = v;
  endtask

  // R3: increment in 15:0, (inc - mod - 1) in 31:16
  task automatic writeRate(input int inc, input int md, input bit tickToo);
    logic [15:0] corr;
    corr = 16'(inc - md - 1);
    @(negedge clk);
    rateWrEn = 1'b1;
    rateWrData = {corr, 16'(inc)};
    if (tickToo) begin tick44k = 1'b1; tick48k = 1'b1; end
    @(negedge clk);
    rateWrEn = 1'b0; tick44k = 1'b0; tick48k = 1'b0;
    mInc = inc; mMod = md; mAcc = 0; mCount = 0;
    check("R7 no strobe after write", int'(sampleStb), 0);
  endtask

  // One tick on a chosen source, then an idle cycle.
  task automatic doTick(input int src);
    int exp;
    @(negedge clk);
    if (src == 1) tick44k = 1'b1; else tick48k = 1'b1;
    @(negedge clk);
    tick44k = 1'b0; tick48k = 1'b0;
    exp = 0;
    if (src == mSel && legal()) begin
      mAcc = mAcc + mInc;
      if (mAcc >= mMod) begin
        mAcc = mAcc - mMod;
        exp = 1;
        mCount++;
      end
    end
    if (src != mSel) check("R2 unselected tick ignored", int'(sampleStb), 0);
    else if (!legal()) check("R8 illegal setting quiet", int'(sampleStb), 0);
    else if (mInc == mMod) check("R9 strobe every tick", int'(sampleStb), 1);
    else check("R4 wrap timing", int'(sampleStb), exp);
    @(negedge clk);
    check("R5 single cycle strobe", int'(sampleStb), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 strobe low in reset", int'(sampleStb), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 strobe low after reset", int'(sampleStb), 0);
    // reset setting is illegal: ticks on either source produce nothing (R1, R8)
    mInc = 0; mMod = 0; mSel = 0;
    for (int i = 0; i < 4; i++) doTick(i % 2);

    // Sweep small settings on both bases (R2, R4, R6, R8, R9)
    for (int inc = 1; inc <= 5; inc++) begin
      for (int md = 0; md <= 9; md++) begin
        writeBase((inc + md) % 2);
        writeRate(inc, md, 1'b0);
        for (int k = 0; k < 12; k++) begin
          doTick(mSel);
          if (k % 5 == 2) doTick(1 - mSel);
        end
        if (legal()) check("R6 strobe count", mCount, (12 * inc) / md);
        else check("R8 strobe count", mCount, 0);
      end
    end

    // R7: write with a coincident tick mid-stream, accumulator restarts
    writeBase(1);
    writeRate(3, 4, 1'b0);
    doTick(1); doTick(1);
    writeRate(3, 4, 1'b1);
    for (int k = 0; k < 8; k++) doTick(1);
    check("R7 count after clear", mCount, (8 * 3) / 4);

    // R3 / R10: wide field values, sums past 16 bits
    writeBase(0);
    writeRate(16'h9000, 16'hF000, 1'b0);
    for (int k = 0; k < 20; k++) doTick(0);
    check("R10 wide count", mCount, (20 * 16'h9000) / 16'hF000);
    writeRate(16'h1234, 16'h5000, 1'b0);
    for (int k = 0; k < 16; k++) doTick(0);
    check("R3 field decode count", mCount, (16 * 16'h1234) / 16'h5000);
    writeRate(16'hFFFF, 16'hFFFF, 1'b0);
    for (int k = 0; k < 4; k++) doTick(0);
    check("R10 full width equal", mCount, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule